// File: doc/BRIEF.md
# Fractional-Dithered Dual-Edge PWM Generator

This block drives a single gate-drive line with a pulse train of fixed frequency. Each period lasts a fixed number of clock cycles, and the pulse width is counted in half-clock steps. A pulse that ends on an odd half step finishes on the falling clock edge, so the block reaches twice the resolution that its clock alone would give.

The duty command has two parts: a whole number of half steps and a binary fraction of one half step. In every period the block picks one of two adjacent widths, N or N+1, so that the average width over many periods follows the fraction. In the accumulating mode the choice comes from the carry of a fraction accumulator, which gives an exact and repeating pattern. In the randomised mode the choice comes from comparing a free-running maximal-length shift register against the fraction. This keeps the same average and spreads the energy of the repeating pattern, so the output carries no strong tones below the PWM rate.

The command is taken only at the start of a period. Widths of zero and of a full period give a line that stays low or stays high, with no glitches.

Top module: `pwm_dither_gen`

## Requirements
- R1: A period lasts exactly PERIOD_CYC clock cycles. A pulse of width greater than zero goes high at the start of the period and stays high without a gap until it ends.
- R2: The high time in each period equals the applied width W, counted in half clock periods. An odd W ends the pulse half a cycle into the clock cycle at index W/2 (integer division), on the falling edge.
- R3: When `dither_en_i` is 0, W is the saturated value of `duty_int_i` plus the carry out of an unsigned FRAC_W-bit accumulator. At each period boundary that accumulator adds `duty_frac_i`. It starts at 0 after reset, and it keeps adding in both modes.
- R4: When `dither_en_i` is 1, W is the saturated value of `duty_int_i` plus 1 if the low FRAC_W bits of the shift register are less than `duty_frac_i`, and plus 0 otherwise. So W is always N or N+1, and a fraction of 0 never adds a step.
- R5: The command inputs (`duty_int_i`, `duty_frac_i`, `dither_en_i`) are sampled only at the clock edge that starts a period. A change at any other time has no effect on the current pulse.
- R6: W saturates at 2*PERIOD_CYC. A width of 0 keeps the output low for the whole period, and a width of 2*PERIOD_CYC keeps it high for the whole period. No short pulse appears when the output moves between these two states.
- R7: While `rst` is high, the output is low. The first clock edge with `rst` low starts the first period.
- R8: The random source is a 16-bit maximal-length shift register that steps every clock. It is seeded with a non-zero value and never holds zero. As a result, the fraction of periods that get the extra step follows `duty_frac_i`/2^FRAC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both of its edges are used |
| rst | input | 1 | Synchronous reset, active high |
| duty_int_i | input | HS_W | Whole part of the width, in half clock steps |
| duty_frac_i | input | FRAC_W | Fraction of one half step, unsigned binary |
| dither_en_i | input | 1 | 1 selects the randomised choice, 0 the accumulator carry |
| pwm_o | output | 1 | Gate-drive output |

## Verification
The bench builds the block with PERIOD_CYC = 20 and FRAC_W = 4, which gives 40 half steps per period and a 6-bit width command. Short periods let several hundred periods fit in one run, so the long-run share of widened periods in the randomised mode can be measured. The 16-value fraction makes the accumulator's carry pattern repeat within a few periods. The 6-bit command can exceed the period length, which brings saturation within reach, as well as the jumps between a line held high and a half-step pulse.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

    localparam int RND_W = 16;

    typedef enum logic {
        PICK_ACCUM  = 1'b0,
        PICK_RANDOM = 1'b1
    } pick_mode_e;

    typedef struct packed {
        logic carry;
        logic below;
    } step_votes_t;

    // Fibonacci form, taps 16,14,13,11 (maximal length).
    function automatic logic [RND_W-1:0] rnd_advance(input logic [RND_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[RND_W-2:0], fb};
    endfunction

    function automatic logic pick_step(input pick_mode_e m, input step_votes_t v);
        return (m == PICK_RANDOM) ? v.below : v.carry;
    endfunction

endpackage

// File: rtl/pwmd_period_ctr.sv
module pwmd_period_ctr #(
    parameter int PERIOD_CYC = 5000,
    parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // The reset value sits on the last count so the first free edge opens a period.
    assign wrap_o     = (cnt_q == LAST);
    assign cnt_next_o = rst ? LAST : (wrap_o ? '0 : cnt_q + 1'b1);
    assign cnt_o      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LAST;
        else     cnt_q <= cnt_next_o;
    end
endmodule

// File: rtl/pwmd_frac_sel.sv
module pwmd_frac_sel
    import pwmd_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int HS_W   = 14,
    parameter int HS_MAX = 10000,
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [HS_W-1:0]   whole_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              rand_i,
    output logic [HS_W-1:0]   width_o,
    output logic [RND_W-1:0]  rnd_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [RND_W-1:0]  rnd_q;
    step_votes_t       votes;
    pick_mode_e        mode;
    logic              extra;
    logic [HS_W:0]     raw;

    assign acc_sum     = {1'b0, acc_q} + {1'b0, frac_i};
    assign votes.carry = acc_sum[FRAC_W];
    assign votes.below = (rnd_q[FRAC_W-1:0] < frac_i);
    assign mode        = rand_i ? PICK_RANDOM : PICK_ACCUM;
    assign extra       = pick_step(mode, votes);

    assign raw     = {1'b0, whole_i} + {{HS_W{1'b0}}, extra};
    assign width_o = (raw > (HS_W+1)'(HS_MAX)) ? HS_W'(HS_MAX) : raw[HS_W-1:0];
    assign rnd_o   = rnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            rnd_q <= SEED;
        end else begin
            rnd_q <= rnd_advance(rnd_q);
            if (step_i) acc_q <= acc_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/pwmd_edge_out.sv
module pwmd_edge_out #(
    parameter int CNT_W = 13,
    parameter int HS_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [HS_W-1:0]  width_next_i,
    output logic             pwm_o
);
    logic [HS_W-1:0] whole_cyc;
    logic            odd_step;
    logic            full_q;   // high through whole cycles of the pulse
    logic            tail_q;   // the single cycle that carries a half step
    logic            ph_rise_q;
    logic            ph_fall_q;

    assign whole_cyc = {1'b0, width_next_i[HS_W-1:1]};
    assign odd_step  = width_next_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q    <= 1'b0;
            tail_q    <= 1'b0;
            ph_rise_q <= 1'b0;
        end else begin
            full_q    <= (HS_W'(cnt_next_i) < whole_cyc);
            tail_q    <= odd_step && (HS_W'(cnt_next_i) == whole_cyc);
            ph_rise_q <= ~ph_rise_q;
        end
    end

    // Catches up with the rising-edge phase half a cycle later.
    always_ff @(negedge clk) begin
        if (rst) ph_fall_q <= 1'b0;
        else     ph_fall_q <= ph_rise_q;
    end

    // Phases differ only during the first half of each cycle.
    assign pwm_o = full_q | (tail_q & (ph_rise_q ^ ph_fall_q));
endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
    import pwmd_pkg::*;
#(
    parameter int PERIOD_CYC = 5000,
    parameter int FRAC_W     = 8,
    parameter logic [RND_W-1:0] SEED = 16'hACE1,
    parameter int HS_W       = $clog2(2*PERIOD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HS_W-1:0]   duty_int_i,
    input  logic [FRAC_W-1:0] duty_frac_i,
    input  logic              dither_en_i,
    output logic              pwm_o
);
    localparam int HS_MAX = 2 * PERIOD_CYC;
    localparam int CNT_W  = $clog2(PERIOD_CYC);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             wrap;
    logic [HS_W-1:0]  width_sel;
    logic [HS_W-1:0]  width_q;
    logic [HS_W-1:0]  width_next;
    logic [RND_W-1:0] rnd_state;

    pwmd_period_ctr #(
        .PERIOD_CYC (PERIOD_CYC),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    pwmd_frac_sel #(
        .FRAC_W (FRAC_W),
        .HS_W   (HS_W),
        .HS_MAX (HS_MAX),
        .SEED   (SEED)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .step_i  (wrap),
        .whole_i (duty_int_i),
        .frac_i  (duty_frac_i),
        .rand_i  (dither_en_i),
        .width_o (width_sel),
        .rnd_o   (rnd_state)
    );

    assign width_next = rst ? '0 : (wrap ? width_sel : width_q);

    always_ff @(posedge clk) begin
        if (rst) width_q <= '0;
        else     width_q <= width_next;
    end

    pwmd_edge_out #(
        .CNT_W (CNT_W),
        .HS_W  (HS_W)
    ) u_out (
        .clk          (clk),
        .rst          (rst),
        .cnt_next_i   (cnt_next),
        .width_next_i (width_next),
        .pwm_o        (pwm_o)
    );
endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker #(
    parameter int PERIOD_CYC = 5000,
    parameter int FRAC_W     = 8,
    parameter int HS_W       = 14,
    parameter int CNT_W      = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [HS_W-1:0]   duty_int_i,
    input logic [FRAC_W-1:0] duty_frac_i,
    input logic              pwm_o,
    input logic              wrap,
    input logic [CNT_W-1:0]  cnt,
    input logic [HS_W-1:0]   width_q,
    input logic [15:0]       rnd_state
);
    localparam int HS_MAX = 2 * PERIOD_CYC;

    function automatic int sat_w(input int v);
        return (v > HS_MAX) ? HS_MAX : v;
    endfunction

    AST_OUT_LOW_RESET: assert property (@(posedge clk) $past(rst) |-> !pwm_o); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < PERIOD_CYC); // R1
    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rnd_state != 16'h0000); // R8
    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(width_q) <= HS_MAX); // R6
    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(width_q)); // R5
    AST_WIDTH_ADJ: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (int'(width_q) == sat_w(int'($past(duty_int_i)))
               || int'(width_q) == sat_w(int'($past(duty_int_i)) + 1))); // R3
    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (rst)
        (wrap && duty_frac_i == '0) |=> int'(width_q) == sat_w(int'($past(duty_int_i)))); // R4
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wrap && int'(duty_int_i) >= HS_MAX) |=> int'(width_q) == HS_MAX); // R6
endmodule

bind pwm_dither_gen pwmd_checker #(
    .PERIOD_CYC (PERIOD_CYC),
    .FRAC_W     (FRAC_W),
    .HS_W       (HS_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .duty_int_i  (duty_int_i),
    .duty_frac_i (duty_frac_i),
    .pwm_o       (pwm_o),
    .wrap        (wrap),
    .cnt         (cnt),
    .width_q     (width_q),
    .rnd_state   (rnd_state)
);

// File: tb/tb_pwm_dither_gen.sv
`timescale 1ns/1ps
module tb_pwm_dither_gen;
    localparam int P      = 20;
    localparam int FW     = 4;
    localparam int HW     = $clog2(2*P + 1);
    localparam int HS_MAX = 2 * P;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] duty_int = '0;
    logic [FW-1:0] duty_frac = '0;
    logic          dither_en = 1'b0;
    logic          pwm;

    pwm_dither_gen #(.PERIOD_CYC(P), .FRAC_W(FW)) dut (
        .clk         (clk),
        .rst         (rst),
        .duty_int_i  (duty_int),
        .duty_frac_i (duty_frac),
        .dither_en_i (dither_en),
        .pwm_o       (pwm)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
        int    sect;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int acc_m  = 0;
    int tot[3] = '{0, 0, 0};
    int hit[3] = '{0, 0, 0};
    bit reported = 0;

    function automatic int sat_w(input int v);
        return (v > HS_MAX) ? HS_MAX : v;
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: applies one period's command and pushes the width it must produce.
    task automatic drive(input int di, input int df, input bit dth,
                         input string tag, input int sect, input bit noisy);
        int   s;
        bit   carry;
        exp_t e;
        duty_int  = HW'(di);
        duty_frac = FW'(df);
        dither_en = dth;
        s     = acc_m + df;
        carry = (s >= (1 << FW));
        acc_m = s % (1 << FW);
        e.tag  = tag;
        e.sect = sect;
        if (dth) begin
            e.lo = sat_w(di);
            e.hi = (df == 0) ? sat_w(di) : sat_w(di + 1);
        end else begin
            e.lo = carry ? sat_w(di + 1) : sat_w(di);
            e.hi = e.lo;
        end
        q.push_back(e);
        if (noisy) begin
            repeat (P/2) @(posedge clk);
            #2;
            duty_int  = HW'((di + 23) % 64);
            duty_frac = ~FW'(df);
            dither_en = ~dth;
            repeat (P - P/2) @(posedge clk);
            #2;
        end else begin
            repeat (P) @(posedge clk);
            #2;
        end
    endtask

    task automatic run(input int n, input int di, input int df, input bit dth,
                       input string tag, input int sect, input bit noisy);
        for (int i = 0; i < n; i++) drive(di, df, dth, tag, sect, noisy);
    endtask

    // Monitor: measures each period in half steps and compares with the queue.
    task automatic monitor();
        forever begin
            int   hi_cnt = 0;
            bit   seen_low = 0;
            bit   gap = 0;
            bit   first = 0;
            exp_t e;
            for (int c = 0; c < P; c++) begin
                @(posedge clk);
                #1.25;
                if (c == 0) first = pwm;
                if (pwm) begin hi_cnt++; if (seen_low) gap = 1; end
                else seen_low = 1;
                #2.5;
                if (pwm) begin hi_cnt++; if (seen_low) gap = 1; end
                else seen_low = 1;
            end
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R1: period with no expected entry, width %0d expected none", hi_cnt);
            end else begin
                e = q[0];
                if (hi_cnt < e.lo || hi_cnt > e.hi) begin
                    errors++;
                    $display("FAIL %s: width %0d expected %0d..%0d", e.tag, hi_cnt, e.lo, e.hi);
                end
                checks++;
                if (gap || (hi_cnt > 0 && !first)) begin
                    errors++;
                    $display("FAIL R1: pulse shape gap=%0d first=%0d expected gap=0 first=1",
                             gap, first);
                end
                if (e.lo != e.hi) begin
                    tot[e.sect]++;
                    if (hi_cnt == e.hi) hit[e.sect]++;
                end
                void'(q.pop_front());
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, elapsed 150000 cycles expected fewer");
        report();
    end

    initial begin
        // R7: output low while reset is held
        repeat (4) begin
            @(posedge clk);
            #1.25;
            checks++;
            if (pwm !== 1'b0) begin
                errors++;
                $display("FAIL R7: output %0b during reset expected 0", pwm);
            end
        end
        @(posedge clk);
        #2;
        rst = 0;
        fork
            monitor();
        join_none

        run(16, 15, 5,  0, "R3", 0, 0);   // odd width, carry pattern (R2 half step)
        run(8,  10, 0,  0, "R3", 0, 0);
        run(3,  0,  0,  0, "R6", 0, 0);   // constant low
        run(3,  50, 0,  0, "R6", 0, 0);   // saturated high
        run(2,  0,  0,  0, "R6", 0, 0);
        run(1,  1,  0,  0, "R2", 0, 0);   // half step from low
        run(2,  40, 15, 0, "R6", 0, 0);   // full width plus carry stays capped
        run(2,  1,  0,  0, "R2", 0, 0);   // half step right after full high
        run(8,  39, 9,  0, "R3", 0, 0);   // carry reaches the cap
        run(6,  22, 3,  0, "R5", 0, 1);   // command disturbed mid-period
        run(4,  7,  12, 0, "R2", 0, 0);
        run(200, 20, 8, 1, "R4", 1, 0);
        run(20, 21, 0,  1, "R4", 0, 0);
        run(200, 13, 15, 1, "R4", 2, 0);
        run(8,  25, 6,  0, "R3", 0, 0);   // accumulator kept adding during dither

        wait (q.size() == 0);
        #1;
        // R8: share of widened periods follows the fraction
        checks++;
        if (hit[1] < tot[1] * 30 / 100 || hit[1] > tot[1] * 70 / 100) begin
            errors++;
            $display("FAIL R8: widened %0d of %0d expected about half", hit[1], tot[1]);
        end
        checks++;
        if (hit[2] < tot[2] * 80 / 100) begin
            errors++;
            $display("FAIL R8: widened %0d of %0d expected about 15/16", hit[2], tot[2]);
        end
        report();
    end
endmodule